// File: doc/BRIEF.md
# Configuration command controller

This block is a small command port that sits inside a system control register bank. Software writes a data word, then writes a control word; the control write is the command. The block keeps a copy of the control word with two reserved bits cleared and decodes that word at once. Status is set to show that the command completed, plus an error bit when the word matches no known code. For the two known codes, the block issues a one-cycle shutdown request or a one-cycle reboot request in the cycle after the write. Software clears the status by writing the status word.

The port exists only on one board variant, chosen by the parameter `CMD_PORT_EN`. When the parameter is 0, the three offsets read as zero and writes to them have no effect. Any access to them raises a one-cycle bad-register flag in the following cycle. The register bus is a simple single-cycle strobe bus with combinational read data. It uses byte offsets 0xA0 (data), 0xA4 (control) and 0xA8 (status). Any other offset reads as zero and is ignored.

A three-state request sequencer drives the request outputs. In `CMD_IDLE` it issues nothing. From any state, a control write whose stored value is the shutdown code moves it to `CMD_SHUTDOWN`, and one whose stored value is the reboot code moves it to `CMD_REBOOT`. Any other cycle returns it to `CMD_IDLE`. `CMD_SHUTDOWN` drives the shutdown request and `CMD_REBOOT` drives the reboot request, each for the one cycle spent in that state.

Top module: `cfg_cmd_ctrl`

## Requirements
- R1: After reset, the data, control and status words read 0 and the shutdown, reboot and bad-register outputs are 0.
- R2: With the port enabled, the data word at offset 0xA0 stores all 32 bits written and reads them back unchanged.
- R3: A write to the control word at offset 0xA4 stores the written value with bits 19 and 18 forced to 0 (for example 0xFFFFFFFF reads back as 0xFFF3FFFF).
- R4: Every control write sets the status word (offset 0xA8) to 1 (bit 0, complete) when the stored value is a known code. It sets the status word to 3 (bit 1, error, also set) for any other stored value.
- R5: A control write whose stored value is 0xC0800000 drives `shutdown_req` high for exactly the one cycle after the write, with `reboot_req` low. Because of the masking in R3, a written value of 0xC08C0000 also counts as this code.
- R6: A control write whose stored value is 0xC0900000 drives `reboot_req` high for exactly the one cycle after the write, with `shutdown_req` low.
- R7: A control write with any other stored value issues neither request, and the two requests are never high together.
- R8: A write to the status word stores only bits 1:0 of the written data (0xFFFFFFFE reads back as 2), so software can clear the status.
- R9: With the port disabled, the three offsets read 0 and writes to them have no effect, including no request. Any read or write to one of them drives `bad_reg` high for exactly the cycle after the access.
- R10: With the port enabled, `bad_reg` stays 0. Offsets other than the three read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reboot_req | output | 1 | One-cycle reboot request |
| bad_reg | output | 1 | One-cycle flag for an access to an offset the variant does not support |

## Verification
A wrong sequencer state shows directly on the request pins in the cycle after the control write. It can show as a missing pulse, a pulse that lasts two cycles, or the wrong request. A bad copy of the control or status word shows on the very next read of that offset, which can be combined with the write under test. A mistake in the mask or in the classification shows both as a wrong status value and as a wrong or missing request. A fault in the variant gating shows on `bad_reg`, or as nonzero read data from the disabled port, one cycle after the access.

// File: rtl/cfg_cmd_pkg.sv
package cfg_cmd_pkg;

    localparam int unsigned WORD_W = 32;

    // Byte offsets of the command port inside the bank
    localparam logic [11:0] OFS_DATA = 12'h0A0;
    localparam logic [11:0] OFS_CTRL = 12'h0A4;
    localparam logic [11:0] OFS_STAT = 12'h0A8;

    // Control bits that are never stored
    localparam logic [WORD_W-1:0] CTRL_DROP_MASK = 32'h000C_0000;

    // Known whole-word command codes
    localparam logic [WORD_W-1:0] CODE_SHUTDOWN = 32'hC080_0000;
    localparam logic [WORD_W-1:0] CODE_REBOOT   = 32'hC090_0000;

    // Status bit positions
    localparam int unsigned STAT_DONE_BIT = 0;
    localparam int unsigned STAT_ERR_BIT  = 1;
    localparam int unsigned STAT_W        = 2;

    typedef enum logic [1:0] {
        CMD_IDLE     = 2'd0,
        CMD_SHUTDOWN = 2'd1,
        CMD_REBOOT   = 2'd2
    } cmd_state_t;

    typedef enum logic [1:0] {
        KIND_OTHER    = 2'd0,
        KIND_SHUTDOWN = 2'd1,
        KIND_REBOOT   = 2'd2
    } cmd_kind_t;

    function automatic cmd_kind_t classify(input logic [WORD_W-1:0] word);
        if (word == CODE_SHUTDOWN)     return KIND_SHUTDOWN;
        else if (word == CODE_REBOOT)  return KIND_REBOOT;
        else                           return KIND_OTHER;
    endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
    import cfg_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_data,
    output logic              hit_ctrl,
    output logic              hit_stat,
    output logic              hit_any,
    output logic              we_data,
    output logic              we_ctrl,
    output logic              we_stat
);

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    always_comb begin
        hit_data = (addr == A_DATA);
        hit_ctrl = (addr == A_CTRL);
        hit_stat = (addr == A_STAT);
        hit_any  = sel && (hit_data || hit_ctrl || hit_stat);
        we_data  = sel && wr && hit_data;
        we_ctrl  = sel && wr && hit_ctrl;
        we_stat  = sel && wr && hit_stat;
    end

endmodule

// File: rtl/cfg_cmd_regs.sv
module cfg_cmd_regs
    import cfg_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_data,
    input  logic              we_ctrl,
    input  logic              we_stat,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] data_q,
    output logic [WORD_W-1:0] ctrl_q,
    output logic [STAT_W-1:0] stat_q,
    output cmd_kind_t         cmd_kind
);

    logic [WORD_W-1:0] ctrl_next;
    logic [STAT_W-1:0] stat_cmd;

    always_comb begin
        ctrl_next = wdata & ~CTRL_DROP_MASK;
        cmd_kind  = classify(ctrl_next);
        stat_cmd  = '0;
        stat_cmd[STAT_DONE_BIT] = 1'b1;
        stat_cmd[STAT_ERR_BIT]  = (cmd_kind == KIND_OTHER);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            ctrl_q <= '0;
            stat_q <= '0;
        end else begin
            if (we_data) data_q <= wdata;
            if (we_ctrl) begin
                ctrl_q <= ctrl_next;
                stat_q <= stat_cmd;
            end else if (we_stat) begin
                stat_q <= wdata[STAT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/cfg_cmd_fsm.sv
module cfg_cmd_fsm
    import cfg_cmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_we,
    input  cmd_kind_t cmd_kind,
    output logic      shutdown_req,
    output logic      reboot_req
);

    cmd_state_t state_q, state_d;

    always_comb begin
        state_d = CMD_IDLE;
        if (cmd_we) begin
            unique case (cmd_kind)
                KIND_SHUTDOWN: state_d = CMD_SHUTDOWN;
                KIND_REBOOT:   state_d = CMD_REBOOT;
                default:       state_d = CMD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        shutdown_req = 1'b0;
        reboot_req   = 1'b0;
        unique case (state_q)
            CMD_IDLE:     ;
            CMD_SHUTDOWN: shutdown_req = 1'b1;
            CMD_REBOOT:   reboot_req   = 1'b1;
            default:      ;
        endcase
    end

endmodule

// File: rtl/cfg_cmd_ctrl.sv
module cfg_cmd_ctrl
    import cfg_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter bit          CMD_PORT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              shutdown_req,
    output logic              reboot_req,
    output logic              bad_reg
);

    logic hit_data, hit_ctrl, hit_stat, hit_any;
    logic we_data_raw, we_ctrl_raw, we_stat_raw;
    logic we_data, we_ctrl, we_stat;
    logic [WORD_W-1:0] data_q, ctrl_q;
    logic [STAT_W-1:0] stat_q;
    cmd_kind_t         cmd_kind;
    logic [WORD_W-1:0] port_rdata;

    cfg_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .sel      (bus_sel),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .hit_data (hit_data),
        .hit_ctrl (hit_ctrl),
        .hit_stat (hit_stat),
        .hit_any  (hit_any),
        .we_data  (we_data_raw),
        .we_ctrl  (we_ctrl_raw),
        .we_stat  (we_stat_raw)
    );

    assign we_data = CMD_PORT_EN && we_data_raw;
    assign we_ctrl = CMD_PORT_EN && we_ctrl_raw;
    assign we_stat = CMD_PORT_EN && we_stat_raw;

    cfg_cmd_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_data  (we_data),
        .we_ctrl  (we_ctrl),
        .we_stat  (we_stat),
        .wdata    (bus_wdata),
        .data_q   (data_q),
        .ctrl_q   (ctrl_q),
        .stat_q   (stat_q),
        .cmd_kind (cmd_kind)
    );

    cfg_cmd_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_we       (we_ctrl),
        .cmd_kind     (cmd_kind),
        .shutdown_req (shutdown_req),
        .reboot_req   (reboot_req)
    );

    always_comb begin
        port_rdata = '0;
        if (bus_sel) begin
            if (hit_data)      port_rdata = data_q;
            else if (hit_ctrl) port_rdata = ctrl_q;
            else if (hit_stat) port_rdata = {{(WORD_W-STAT_W){1'b0}}, stat_q};
        end
    end

    generate
        if (CMD_PORT_EN) begin : g_port
            assign bus_rdata = port_rdata;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) bad_reg <= 1'b0;
                else        bad_reg <= 1'b0 & hit_any;
            end
        end else begin : g_noport
            assign bus_rdata = port_rdata & '0;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) bad_reg <= 1'b0;
                else        bad_reg <= hit_any;
            end
        end
    endgenerate

endmodule

// File: rtl/cfg_cmd_ctrl_chk.sv
module cfg_cmd_ctrl_chk
    import cfg_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter bit          CMD_PORT_EN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              shutdown_req,
    input logic              reboot_req,
    input logic              bad_reg
);

    logic ctl_wr, port_acc, stat_rd;
    logic [WORD_W-1:0] kept;
    assign kept     = bus_wdata & ~CTRL_DROP_MASK;
    assign ctl_wr   = CMD_PORT_EN && bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign stat_rd  = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
    assign port_acc = bus_sel && ((bus_addr == ADDR_W'(OFS_DATA)) ||
                                  (bus_addr == ADDR_W'(OFS_CTRL)) ||
                                  (bus_addr == ADDR_W'(OFS_STAT)));

    // R5
    shutdown_follows_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && kept == CODE_SHUTDOWN) |=> (shutdown_req && !reboot_req));

    // R6
    reboot_follows_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && kept == CODE_REBOOT) |=> (reboot_req && !shutdown_req));

    // R7
    requests_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shutdown_req, reboot_req}));

    // R7
    request_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && kept != CODE_SHUTDOWN && kept != CODE_REBOOT) |=> (!shutdown_req && !reboot_req));

    // R4
    status_done_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (!stat_rd || bus_rdata[STAT_DONE_BIT]));

    // R9
    bad_reg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bad_reg) |-> $past(port_acc && !CMD_PORT_EN));

    // R9
    disabled_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !CMD_PORT_EN |-> (bus_rdata == '0 && !shutdown_req && !reboot_req));

    // R10
    enabled_never_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        CMD_PORT_EN |-> !bad_reg);

endmodule

bind cfg_cmd_ctrl cfg_cmd_ctrl_chk #(.ADDR_W(ADDR_W), .CMD_PORT_EN(CMD_PORT_EN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .shutdown_req (shutdown_req),
    .reboot_req   (reboot_req),
    .bad_reg      (bad_reg)
);

// File: tb/test_cfg_cmd_ctrl.sv
`timescale 1ns/1ps
module test_cfg_cmd_ctrl;

    localparam int unsigned AW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_en = 1'b0, sel_dis = 1'b0;
    logic wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_en, rd_dis;
    logic sd_en, rb_en, bad_en, sd_dis, rb_dis, bad_dis;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [31:0] got;

    always #2 clk = ~clk;

    cfg_cmd_ctrl #(.ADDR_W(AW), .CMD_PORT_EN(1'b1)) i_cfg_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_en), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd_en), .shutdown_req(sd_en),
        .reboot_req(rb_en), .bad_reg(bad_en));

    cfg_cmd_ctrl #(.ADDR_W(AW), .CMD_PORT_EN(1'b0)) i_cfg_cmd_ctrl_off (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_dis), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd_dis), .shutdown_req(sd_dis),
        .reboot_req(rb_dis), .bad_reg(bad_dis));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Access ends at the falling edge after the capturing rising edge
    task automatic bus_write(input bit dis, input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        sel_en = !dis; sel_dis = dis; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel_en = 1'b0; sel_dis = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input bit dis, input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        sel_en = !dis; sel_dis = dis; wr = 1'b0; addr = a;
        #1;
        d = dis ? rd_dis : rd_en;
        @(negedge clk);
        sel_en = 1'b0; sel_dis = 1'b0;
    endtask

    task automatic t_reset;
        bus_read(0, 12'h0A0, got); check("R1 data", got, 0);
        bus_read(0, 12'h0A4, got); check("R1 ctrl", got, 0);
        bus_read(0, 12'h0A8, got); check("R1 stat", got, 0);
        check("R1 outputs", {29'd0, sd_en, rb_en, bad_en}, 0);
    endtask

    task automatic t_data;
        bus_write(0, 12'h0A0, 32'hDEAD_BEEF);
        bus_read(0, 12'h0A0, got); check("R2 data a", got, 32'hDEAD_BEEF);
        bus_write(0, 12'h0A0, 32'h1234_5678);
        bus_read(0, 12'h0A0, got); check("R2 data b", got, 32'h1234_5678);
    endtask

    task automatic t_unknown;
        bus_write(0, 12'h0A4, 32'hFFFF_FFFF);
        check("R7 no request", {30'd0, sd_en, rb_en}, 0);
        bus_read(0, 12'h0A4, got); check("R3 ctrl mask", got, 32'hFFF3_FFFF);
        bus_read(0, 12'h0A8, got); check("R4 stat error", got, 3);
    endtask

    task automatic t_status;
        bus_write(0, 12'h0A8, 32'hFFFF_FFFE);
        bus_read(0, 12'h0A8, got); check("R8 stat low bits", got, 2);
        bus_write(0, 12'h0A8, 32'h0);
        bus_read(0, 12'h0A8, got); check("R8 stat clear", got, 0);
    endtask

    task automatic t_shutdown;
        bus_write(0, 12'h0A4, 32'hC08C_0000);
        check("R5 shutdown pulse", {30'd0, sd_en, rb_en}, 2);
        @(negedge clk);
        check("R5 shutdown ends", {30'd0, sd_en, rb_en}, 0);
        bus_read(0, 12'h0A4, got); check("R3 ctrl stored", got, 32'hC080_0000);
        bus_read(0, 12'h0A8, got); check("R4 stat done", got, 1);
    endtask

    task automatic t_reboot;
        bus_write(0, 12'h0A4, 32'hC090_0000);
        check("R6 reboot pulse", {30'd0, sd_en, rb_en}, 1);
        @(negedge clk);
        check("R6 reboot ends", {30'd0, sd_en, rb_en}, 0);
        bus_read(0, 12'h0A8, got); check("R4 stat after reboot", got, 1);
        bus_write(0, 12'h0A4, 32'hC090_0001);
        check("R7 near code", {30'd0, sd_en, rb_en}, 0);
    endtask

    task automatic t_disabled;
        bus_write(1, 12'h0A0, 32'hAAAA_5555);
        check("R9 bad after data write", {31'd0, bad_dis}, 1);
        @(negedge clk);
        check("R9 bad one cycle", {31'd0, bad_dis}, 0);
        bus_write(1, 12'h0A4, 32'hC080_0000);
        check("R9 no request", {29'd0, sd_dis, rb_dis, bad_dis}, 1);
        bus_read(1, 12'h0A0, got); check("R9 data reads zero", got, 0);
        check("R9 bad after read", {31'd0, bad_dis}, 1);
        bus_read(1, 12'h0A8, got); check("R9 stat reads zero", got, 0);
        bus_read(1, 12'h040, got);
        check("R9 other offset not bad", {31'd0, bad_dis}, 0);
    endtask

    task automatic t_enabled_bad;
        bus_write(0, 12'h0A0, 32'h0000_0001);
        check("R10 no bad on write", {31'd0, bad_en}, 0);
        bus_read(0, 12'h040, got); check("R10 other offset zero", got, 0);
        check("R10 no bad on read", {31'd0, bad_en}, 0);
    endtask

    initial begin
        #1;
        check("R1 outputs in reset", {29'd0, sd_en, rb_en, bad_en}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_data;
        t_unknown;
        t_status;
        t_shutdown;
        t_reboot;
        t_disabled;
        t_enabled_bad;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule